// File: doc/BRIEF.md
# Dual-Issue Slot Pairing Checker

This block is a cycle-accounting model for a two-wide in-order issue stage. Instructions arrive one at a time, in program order, on a valid/ready input. Each instruction carries a 4-bit functional-unit class code and a flag that says whether it depends on the instruction just before it. For each accepted instruction, the block decides whether the instruction can join the issue cycle that is already open, or whether it must start a new one.

A cycle has a budget of two issue slots in total. On top of that, each functional-unit class has its own quota per cycle. Compare, branch and jump allow one instruction per cycle. Every other class allows two. A dependency on the previous instruction always splits the cycle, even when slots are still free. When a split happens, all budgets are refilled and the incoming instruction is then charged against the fresh budget. Two saturating counters record the number of cycles opened and the number of those splits that a dependency caused. The block is meant to sit beside a functional model or trace replayer and turn an instruction stream into an issue-cycle estimate.

Top module: `issue_pair_check`

## Requirements
- R1: While reset is held, and on the first sample after it is released, `new_cycle` is 0 and both counters are 0. `in_ready` is 1 from the first clock after release. All budgets start full, so the first independent instruction does not open a cycle.
- R2: At most 2 instructions share a cycle. A third independent instruction opens a new cycle, even when its class quota would still allow it.
- R3: Class codes 2 (compare), 3 (branch) and 4 (jump) each have a quota of 1 per cycle. A second instruction of the same such class in one cycle opens a new cycle. Two different classes among these three may share a cycle.
- R4: Class codes 0 (unknown), 1 (shift) and 5 to 11 (extend, nop, move, move-immediate, arithmetic, store, load) have a quota of 2. The unassigned codes 12 to 15 also have a quota of 2. Two instructions of one of these classes may share a cycle.
- R5: An accepted instruction with `in_dep`=1 always opens a new cycle, whatever budget remains.
- R6: When a cycle is opened, every class quota and the total slot budget are refilled before the incoming instruction is charged. The next independent instruction of a different class, or of a quota-2 class, can therefore share that cycle.
- R7: `new_cycle` pulses for one clock, in the cycle after the accepting edge of an instruction that opened a cycle. `cycle_count` is incremented at that same edge.
- R8: `hazard_count` is incremented at the same edge as `cycle_count` exactly when the splitting instruction had `in_dep`=1.
- R9: In a cycle with no accepted instruction, `new_cycle` is 0 on the next sample and neither counter changes.
- R10: The two counters are `CNT_W` bits wide (32 by default) and hold at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The block accepts instructions (high after reset) |
| in_class | input | 4 | Functional-unit class code |
| in_dep | input | 1 | The instruction depends on the previous one |
| new_cycle | output | 1 | The last accepted instruction opened a new issue cycle |
| cycle_count | output | CNT_W | Number of issue cycles opened (saturating) |
| hazard_count | output | CNT_W | Number of cycles opened by a dependency (saturating) |

## Verification
The properties assume that `in_class` and `in_dep` are known whenever `in_valid` is high. They also assume that reset is held for at least two clocks, so that each comparison with a previous cycle sees cleared counters. The stimulus drives every input only on the falling edge and keeps it at a defined value at all times, including idle cycles, where the class and dependency inputs take random values. The random stream covers all 16 class codes, with a dependency rate of about one in six and occasional idle gaps. A second instance with 3-bit counters is fed the same stream, so that saturation is reached within the run.

// File: rtl/ipc_pkg.sv
// Package: shared class encoding and quota table for the issue pairing checker.
// Assumes a 4-bit class code; codes above LOAD are unassigned and get the wide quota.
package ipc_pkg;

    localparam int CLS_W     = 4;
    localparam int NUM_CLASS = 1 << CLS_W;

    typedef enum logic [CLS_W-1:0] {
        CLS_UNKNOWN = 4'd0,
        CLS_SHIFT   = 4'd1,
        CLS_CMP     = 4'd2,
        CLS_BRANCH  = 4'd3,
        CLS_JUMP    = 4'd4,
        CLS_EXTEND  = 4'd5,
        CLS_NOP     = 4'd6,
        CLS_MOVE    = 4'd7,
        CLS_MOVI    = 4'd8,
        CLS_ARITH   = 4'd9,
        CLS_STORE   = 4'd10,
        CLS_LOAD    = 4'd11
    } unit_cls_e;

    // Per-cycle quota of a class: control-flow and compare are single, the rest double.
    function automatic int unsigned class_quota(int unsigned idx);
        case (idx)
            int'(CLS_CMP), int'(CLS_BRANCH), int'(CLS_JUMP): class_quota = 1;
            default:                                         class_quota = 2;
        endcase
    endfunction

endpackage

// File: rtl/ipc_quota_bank.sv
// Module: one quota counter per functional-unit class.
// Assumes the caller charges a class only when its quota is non-zero, or on a reload.
module ipc_quota_bank
    import ipc_pkg::*;
#(
    parameter int N_CLS = NUM_CLASS,
    parameter int QW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             charge,
    input  logic             reload,
    input  logic [CLS_W-1:0] cls,
    output logic             cls_empty
);

    logic [N_CLS-1:0] empty_vec;

    for (genvar g = 0; g < N_CLS; g++) begin : g_cls
        localparam logic [QW-1:0] INIT = QW'(class_quota(g));
        logic [QW-1:0] quota_q;
        logic          hit;

        assign hit = charge && (cls == CLS_W'(g));

        // Refill on reset or on a new cycle, then charge the incoming class.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quota_q <= INIT;
            end else if (reload) begin
                quota_q <= hit ? INIT - QW'(1) : INIT;
            end else if (hit) begin
                quota_q <= quota_q - QW'(1);
            end
        end

        assign empty_vec[g] = (quota_q == '0);
    end

    assign cls_empty = empty_vec[cls];

endmodule

// File: rtl/ipc_slot_ctr.sv
// Module: total issue-slot budget of the open cycle.
// Assumes a charge without a reload arrives only while the budget is non-zero.
module ipc_slot_ctr #(
    parameter int ISSUE_W = 2,
    parameter int SW      = $clog2(ISSUE_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic charge,
    input  logic reload,
    output logic slots_empty
);

    localparam logic [SW-1:0] FULL = SW'(ISSUE_W);

    logic [SW-1:0] slots_q;

    // Refill on reset or on a new cycle, then take one slot per accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= FULL;
        end else if (reload) begin
            slots_q <= charge ? FULL - SW'(1) : FULL;
        end else if (charge) begin
            slots_q <= slots_q - SW'(1);
        end
    end

    assign slots_empty = (slots_q == '0);

endmodule

// File: rtl/ipc_sat_ctr.sv
// Module: event counter that stops at all ones.
// Assumes one increment request per clock at most.
module ipc_sat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count events, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/issue_pair_check.sv
// Module: decides per instruction whether it joins the open issue cycle or opens a new one.
// Assumes in-order delivery; the dependency flag is computed upstream.
module issue_pair_check
    import ipc_pkg::*;
#(
    parameter int ISSUE_W = 2,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CLS_W-1:0] in_class,
    input  logic             in_dep,
    output logic             new_cycle,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] hazard_count
);

    localparam int QW = $clog2(ISSUE_W + 1);

    logic accept;
    logic cls_empty;
    logic slots_empty;
    logic split;
    logic ready_q;
    logic new_cycle_q;

    assign accept = in_valid && ready_q;
    assign split  = accept && (cls_empty || slots_empty || in_dep);

    // Ready rises one clock after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Register the split decision as a one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) new_cycle_q <= 1'b0;
        else        new_cycle_q <= split;
    end

    ipc_quota_bank #(.N_CLS(NUM_CLASS), .QW(QW)) u_quota (
        .clk       (clk),
        .rst_n     (rst_n),
        .charge    (accept),
        .reload    (split),
        .cls       (in_class),
        .cls_empty (cls_empty)
    );

    ipc_slot_ctr #(.ISSUE_W(ISSUE_W)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .charge      (accept),
        .reload      (split),
        .slots_empty (slots_empty)
    );

    ipc_sat_ctr #(.W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (split),
        .count (cycle_count)
    );

    ipc_sat_ctr #(.W(CNT_W)) u_haz (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (split && in_dep),
        .count (hazard_count)
    );

    assign in_ready  = ready_q;
    assign new_cycle = new_cycle_q;

endmodule

// File: rtl/ipc_pair_sva.sv
// Checker: temporal properties of the issue pairing checker, attached by bind.
// Assumes reset is held for at least two clocks.
module ipc_pair_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_dep,
    input logic             new_cycle,
    input logic [CNT_W-1:0] cycle_count,
    input logic [CNT_W-1:0] hazard_count
);

    // R5: a dependent accepted instruction opens a cycle.
    a_r5_dep_splits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dep) |=> new_cycle);

    // R9: no acceptance means no strobe and no count change.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (!new_cycle && $stable(cycle_count) && $stable(hazard_count)));

    // R7: the strobe goes with one step of the cycle counter, or the counter is held at its maximum.
    a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        new_cycle |-> ((cycle_count == $past(cycle_count) + CNT_W'(1)) || ($past(cycle_count) == '1)));

    // R7: without a strobe the cycle counter holds.
    a_r7_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !new_cycle |-> $stable(cycle_count));

    // R8: a hazard count change happens only with a new cycle.
    a_r8_hazard_with_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hazard_count) |-> new_cycle);

    // R10: counters never wrap to a smaller value.
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_count >= $past(cycle_count)) && (hazard_count >= $past(hazard_count)));

endmodule

bind issue_pair_check ipc_pair_sva #(.CNT_W(CNT_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_dep       (in_dep),
    .new_cycle    (new_cycle),
    .cycle_count  (cycle_count),
    .hazard_count (hazard_count)
);

// File: tb/sim_issue_pair_check.sv
`timescale 1ns/1ps
module sim_issue_pair_check;

    localparam int SAT_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_class = 4'd0;
    logic        in_dep = 1'b0;
    logic        in_ready, in_ready_s;
    logic        new_cycle, new_cycle_s;
    logic [31:0] cycle_count, hazard_count;
    logic [SAT_W-1:0] cyc_s, haz_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state.
    int rq[16];
    int rtot;
    longint rcyc, rhaz;

    always #10 clk = ~clk;

    issue_pair_check u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_dep(in_dep), .new_cycle(new_cycle),
        .cycle_count(cycle_count), .hazard_count(hazard_count)
    );

    issue_pair_check #(.CNT_W(SAT_W)) u_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_s),
        .in_class(in_class), .in_dep(in_dep), .new_cycle(new_cycle_s),
        .cycle_count(cyc_s), .hazard_count(haz_s)
    );

    function automatic int quota_of(int c);
        return (c == 2 || c == 3 || c == 4) ? 1 : 2;
    endfunction

    function automatic longint sat(longint v, int w);
        longint mx = (64'd1 << w) - 1;
        return (v > mx) ? mx : v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) rq[i] = quota_of(i);
        rtot = 2; rcyc = 0; rhaz = 0;
    endtask

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_counts();
        check(cycle_count == 32'(rcyc), "R7 cycle_count", cycle_count, rcyc);
        check(hazard_count == 32'(rhaz), "R8 hazard_count", hazard_count, rhaz);
        check(cyc_s == SAT_W'(sat(rcyc, SAT_W)), "R10 sat cycle", cyc_s, sat(rcyc, SAT_W));
        check(haz_s == SAT_W'(sat(rhaz, SAT_W)), "R10 sat hazard", haz_s, sat(rhaz, SAT_W));
    endtask

    // Offer one instruction, update the model, and check the strobe on the next falling edge.
    task automatic send(int c, bit d, string tag);
        bit exp_split;
        exp_split = d || (rq[c] < 1) || (rtot < 1);
        in_valid = 1'b1; in_class = 4'(c); in_dep = d;
        @(posedge clk);
        if (exp_split) begin
            for (int i = 0; i < 16; i++) rq[i] = quota_of(i);
            rtot = 2; rcyc++;
            if (d) rhaz++;
        end
        rq[c]--; rtot--;
        @(negedge clk);
        in_valid = 1'b0;
        check(new_cycle == exp_split, tag, new_cycle, exp_split);
        check(new_cycle_s == exp_split, tag, new_cycle_s, exp_split);
        check_counts();
    endtask

    // One cycle with nothing offered and random side inputs.
    task automatic idle();
        in_valid = 1'b0; in_class = 4'($urandom_range(15)); in_dep = 1'($urandom_range(1));
        @(posedge clk);
        @(negedge clk);
        check(new_cycle == 1'b0, "R9 idle strobe", new_cycle, 0);
        check_counts();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        check(new_cycle == 1'b0, "R1 strobe in reset", new_cycle, 0);
        check(cycle_count == 0, "R1 count in reset", cycle_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        check(new_cycle == 1'b0, "R1 strobe after reset", new_cycle, 0);
        check(cycle_count == 0 && hazard_count == 0, "R1 counters", cycle_count, 0);

        // Directed corners.
        send(9, 0, "R1 first insn no split");
        send(9, 0, "R4 arith pair shares");
        send(9, 0, "R2 third insn splits");
        send(7, 0, "R6 refill lets pair");
        send(2, 0, "R2 width after refill");
        send(2, 0, "R3 second compare splits");
        send(3, 0, "R3 branch pairs with compare");
        send(4, 0, "R2 jump at full width");
        send(4, 0, "R3 second jump splits");
        send(13, 1, "R5 dep splits with slots left");
        send(13, 0, "R4 unassigned code quota 2");
        idle();
        send(15, 1, "R5 dep at full width");
        send(12, 1, "R5 dep back to back");
        send(0, 0, "R4 unknown shares after dep");
        send(3, 0, "R2 third splits");
        send(3, 1, "R5 dep on exhausted class");
        send(11, 0, "R6 load after split");
        idle();
        idle();

        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(9) == 0) idle();
            else send(int'($urandom_range(15)), ($urandom_range(5) == 0), "R6 random stream");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule